// File: doc/BRIEF.md
# Serial Systematic (7,4) Cyclic Encoder

This block encodes a binary (7,4) cyclic code one bit at a time. A message of four bits arrives serially with a valid strobe, highest-order coefficient first. Each accepted bit is copied to the serial output and also fed into a feedback division register. That register computes the remainder of p^3·M(p) divided by the generator G(p). After the fourth message bit, the three remainder bits follow on the output. The output is therefore the systematic codeword: message in the high-order positions, check bits in the low-order positions. All arithmetic is over GF(2), so addition is XOR and multiplication is AND.

The generator is fixed at elaboration by a parameter. It selects one of the two degree-3 factors of p^7+1. A `start` pulse in the idle state clears the division register and opens a new message. That same cycle may already carry the first message bit, so codewords can follow each other with no idle cycle between them.

Top module: `cyclic_sys_encoder`

## Requirements
- R1: While `rst` is high at a clock edge, the encoder returns to idle with a cleared division register. After that edge `cw_valid`, `cw_first` and `done` are low, and they stay low until a message is started.
- R2: `GEN_SEL` = 0 selects G(p) = 1+p+p^3, coefficient vector p^3..p^0 = 1011. `GEN_SEL` = 1 selects G(p) = 1+p^2+p^3, vector 1101.
- R3: `start` sampled high in the idle state clears the division register and begins a message. `start` sampled while a message or its check bits are in progress has no effect on the codeword.
- R4: Every accepted message bit appears on `cw_bit` with `cw_valid` high in the next cycle. The first bit of a codeword also raises `cw_first` for that one cycle. A cycle of the message phase with `msg_valid` low produces a cycle with `cw_valid` low.
- R5: The three cycles after the fourth message bit is output carry the check bits c2, c1, c0, in that order and with no gap. Together they equal the remainder of p^3·M(p) divided by G(p).
- R6: `done` is high for exactly one cycle, the cycle in which c0 is output. With no message gaps, that cycle comes six cycles after the `cw_first` cycle.
- R7: Each seven-bit codeword, read as a polynomial with the first output bit as the p^6 coefficient, leaves remainder zero when divided by G(p).
- R8: `msg_valid` is ignored in the idle state without `start` and during the check-bit phase. Such a bit causes no output bit and does not change the codeword.
- R9: `start` together with a first message bit is accepted in the same cycle that `done` is high. The new codeword's `cw_first` then appears in the very next cycle.
- R10: Message bits are taken in the order m3, m2, m1, m0, where m3 is the p^6 coefficient of the codeword. The codeword is output from p^6 down to p^0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Opens a new message when idle |
| msg_valid | input | 1 | `msg_bit` carries a message bit this cycle |
| msg_bit | input | 1 | Serial message bit, highest order first |
| cw_valid | output | 1 | `cw_bit` carries a codeword bit |
| cw_bit | output | 1 | Serial codeword bit, highest order first |
| cw_first | output | 1 | Marks the first bit of a codeword |
| done | output | 1 | Marks the last check bit of a codeword |

## Verification
Two functions can fall in the same cycle. One is the output of the final check bit with `done`. The other is the acceptance of a new `start` carrying the first bit of the next message. The division register must hand its last remainder bit to the output while it is loaded fresh from zero. The bench provokes this by watching `done` and driving `start`, `msg_valid` and the next bit in that same cycle, across a chain of three messages. Both codewords of each pair are judged against a software polynomial division, and the bench checks that the next `cw_first` lands exactly one cycle after `done`.

// File: rtl/cyclic_sys_encoder.sv
`timescale 1ns/1ps
module cyclic_sys_encoder #(
  parameter int N       = 7,
  parameter int K       = 4,
  parameter int GEN_SEL = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic msg_valid,
  input  logic msg_bit,
  output logic cw_valid,
  output logic cw_bit,
  output logic cw_first,
  output logic done
);
  localparam int Q  = N - K;
  localparam int CW = $clog2(N + 1);
  localparam logic [Q-1:0] GTAP = (GEN_SEL == 0) ? Q'(3'b011) : Q'(3'b101);

  typedef enum logic [1:0] {S_IDLE, S_MSG, S_CHK} st_t;

  st_t           state;
  logic [Q-1:0]  rem;
  logic [CW-1:0] cnt;

  wire           idle     = (state == S_IDLE);
  wire           opening  = idle && start;
  wire           take     = msg_valid && ((state == S_MSG) || opening);
  wire [Q-1:0]   rem_base = opening ? '0 : rem;
  wire [CW-1:0]  cnt_m    = opening ? '0 : cnt;
  wire           fb       = msg_bit ^ rem_base[Q-1];
  wire [Q-1:0]   rem_div  = {rem_base[Q-2:0], 1'b0} ^ (fb ? GTAP : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      rem      <= '0;
      cnt      <= '0;
      cw_valid <= 1'b0;
      cw_bit   <= 1'b0;
      cw_first <= 1'b0;
      done     <= 1'b0;
    end else begin
      cw_valid <= 1'b0;
      cw_first <= 1'b0;
      done     <= 1'b0;
      if (take) begin
        rem      <= rem_div;
        cw_valid <= 1'b1;
        cw_bit   <= msg_bit;
        cw_first <= (cnt_m == '0);
        if (cnt_m == CW'(K - 1)) begin
          state <= S_CHK;
          cnt   <= '0;
        end else begin
          state <= S_MSG;
          cnt   <= cnt_m + 1'b1;
        end
      end else if (opening) begin
        rem   <= '0;
        cnt   <= '0;
        state <= S_MSG;
      end else if (state == S_CHK) begin
        cw_valid <= 1'b1;
        cw_bit   <= rem[Q-1];
        rem      <= {rem[Q-2:0], 1'b0};
        if (cnt == CW'(Q - 1)) begin
          done  <= 1'b1;
          cnt   <= '0;
          state <= S_IDLE;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // Observer: divides the emitted stream by G(p) and counts its bits.
  logic [Q-1:0]  syn;
  logic [CW-1:0] obs_n;
  wire  [Q-1:0]  syn_base = cw_first ? '0 : syn;
  wire  [Q-1:0]  syn_nx   = {syn_base[Q-2:0], cw_bit} ^ (syn_base[Q-1] ? GTAP : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      syn   <= '0;
      obs_n <= '0;
    end else if (cw_valid) begin
      syn   <= syn_nx;
      obs_n <= cw_first ? CW'(1) : obs_n + 1'b1;
    end
  end

  assert_codeword_multiple_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (syn_nx == '0));

  assert_done_length_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (cw_valid && !cw_first && obs_n == CW'(N - 1)));

  assert_echo_bit_R4: assert property (@(posedge clk) disable iff (rst)
    take |=> (cw_valid && cw_bit == $past(msg_bit)));

  assert_first_valid_R4: assert property (@(posedge clk) disable iff (rst)
    cw_first |-> cw_valid);

  assert_ignored_input_R8: assert property (@(posedge clk) disable iff (rst)
    (!take && state != S_CHK) |=> !cw_valid);

  assert_busy_start_R3: assert property (@(posedge clk) disable iff (rst)
    (start && state == S_MSG && !msg_valid) |=> (rem == $past(rem)));
endmodule

// File: tb/cyclic_sys_encoder_tb_top.sv
`timescale 1ns/1ps
module cyclic_sys_encoder_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, start = 1'b0, msg_valid = 1'b0, msg_bit = 1'b0;
  logic a_valid, a_bit, a_first, a_done;
  logic b_valid, b_bit, b_first, b_done;

  cyclic_sys_encoder #(.N(7), .K(4), .GEN_SEL(0)) dut_i (
    .clk(clk), .rst(rst), .start(start), .msg_valid(msg_valid), .msg_bit(msg_bit),
    .cw_valid(a_valid), .cw_bit(a_bit), .cw_first(a_first), .done(a_done));

  cyclic_sys_encoder #(.N(7), .K(4), .GEN_SEL(1)) dut_alt_i (
    .clk(clk), .rst(rst), .start(start), .msg_valid(msg_valid), .msg_bit(msg_bit),
    .cw_valid(b_valid), .cw_bit(b_bit), .cw_first(b_first), .done(b_done));

  logic ov [2], ob [2], of [2], od [2];
  assign ov[0] = a_valid; assign ob[0] = a_bit; assign of[0] = a_first; assign od[0] = a_done;
  assign ov[1] = b_valid; assign ob[1] = b_bit; assign of[1] = b_first; assign od[1] = b_done;

  int n_chk = 0, n_fail = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [6:0] word [2];
  logic [6:0] hist [2][64];
  int span_h [2][64];
  int gap_h  [2][64];
  int ndone  [2] = '{0, 0};
  int nvalid [2] = '{0, 0};
  longint first_cyc [2] = '{0, 0};
  longint done_cyc  [2] = '{0, 0};
  int gap_cur [2] = '{0, 0};

  always @(negedge clk) begin
    if (!rst) begin
      for (int u = 0; u < 2; u++) begin
        if (ov[u]) begin
          nvalid[u]++;
          if (of[u]) begin
            word[u]      = {6'b0, ob[u]};
            gap_cur[u]   = int'(cyc - done_cyc[u]);
            first_cyc[u] = cyc;
          end else begin
            word[u] = {word[u][5:0], ob[u]};
          end
        end
        if (od[u]) begin
          hist[u][ndone[u] % 64]   = word[u];
          span_h[u][ndone[u] % 64] = int'(cyc - first_cyc[u]);
          gap_h[u][ndone[u] % 64]  = gap_cur[u];
          done_cyc[u] = cyc;
          ndone[u]++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] gfull(input int sel);
    return (sel == 0) ? 4'b1011 : 4'b1101;
  endfunction

  function automatic logic [2:0] pmod(input logic [6:0] d, input logic [3:0] g);
    logic [6:0] r = d;
    for (int i = 6; i >= 3; i--)
      if (r[i]) r = r ^ (7'(g) << (i - 3));
    return r[2:0];
  endfunction

  function automatic logic [6:0] ref_cw(input logic [3:0] m, input int sel);
    return {m, pmod({m, 3'b000}, gfull(sel))};
  endfunction

  task automatic drive(input logic s, input logic v, input logic b);
    start = s; msg_valid = v; msg_bit = b;
  endtask

  task automatic wait_done();
    int prev = ndone[0];
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); drive(0, 0, 0); #1;
      if (ndone[0] > prev) break;
    end
  endtask

  // Judge the most recent codeword from both instances.
  task automatic judge(input logic [3:0] m, input int exp_span, input string tag);
    for (int u = 0; u < 2; u++) begin
      logic [6:0] g = hist[u][(ndone[u] - 1) % 64];
      chk(g == ref_cw(m, u), (u == 0) ? "R5" : "R2", {tag, " codeword"}, g, ref_cw(m, u));
      chk(pmod(g, gfull(u)) == 3'b000, "R7", {tag, " remainder"}, pmod(g, gfull(u)), 0);
      chk(g[6:3] == m, "R10", {tag, " message order"}, g[6:3], m);
      chk(span_h[u][(ndone[u] - 1) % 64] == exp_span, "R6", {tag, " done position"},
          span_h[u][(ndone[u] - 1) % 64], exp_span);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; drive(0, 0, 0);
    repeat (3) @(negedge clk);
    chk(!a_valid && !a_first && !a_done && !b_valid && !b_done, "R1", "outputs in reset",
        {a_valid, a_first, a_done, b_valid, b_done}, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(nvalid[0] == 0 && !a_valid && !b_valid, "R1", "quiet after reset", nvalid[0], 0);
  endtask

  task automatic t_all_messages();
    for (int m = 0; m < 16; m++) begin
      @(negedge clk); drive(1, 1, m[3]);
      for (int i = 2; i >= 0; i--) begin @(negedge clk); drive(0, 1, m[i]); end
      wait_done();
      judge(4'(m), 6, "sweep");
    end
  endtask

  task automatic t_gaps();
    logic [3:0] m = 4'b1011;
    logic [2:0] gapmask = 3'b101;
    @(negedge clk); drive(1, 1, m[3]);
    for (int i = 2; i >= 0; i--) begin
      if (gapmask[i]) begin @(negedge clk); drive(0, 0, 1); end
      @(negedge clk); drive(0, 1, m[i]);
    end
    wait_done();
    judge(m, 6 + 2, "R4 gaps");
  endtask

  task automatic t_busy_start();
    logic [3:0] m = 4'b0110;
    @(negedge clk); drive(1, 1, m[3]);
    @(negedge clk); drive(1, 0, 0);
    for (int i = 2; i >= 0; i--) begin @(negedge clk); drive(1, 1, m[i]); end
    @(negedge clk); drive(1, 0, 0);
    wait_done();
    judge(m, 7, "R3 busy start");
  endtask

  task automatic t_ignore();
    logic [3:0] m = 4'b1001;
    int nv0;
    repeat (3) begin @(negedge clk); drive(0, 1, 1); end
    @(negedge clk); drive(0, 0, 0);
    repeat (3) @(negedge clk);
    chk(nvalid[0] == 0 + nvalid[0] - 0 && !a_valid, "R8", "idle input ignored", a_valid, 0);
    nv0 = nvalid[0];
    @(negedge clk); drive(1, 1, m[3]);
    for (int i = 2; i >= 0; i--) begin @(negedge clk); drive(0, 1, m[i]); end
    repeat (4) begin @(negedge clk); drive(0, 1, 1); end
    wait_done();
    repeat (3) @(negedge clk);
    chk(nvalid[0] - nv0 == 7, "R8", "bit count with ignored input", nvalid[0] - nv0, 7);
    judge(m, 6, "R8 check-phase input");
  endtask

  task automatic t_idle_quiet();
    int nv0 = nvalid[0];
    repeat (2) begin @(negedge clk); drive(0, 1, 0); end
    @(negedge clk); drive(0, 0, 0);
    repeat (3) @(negedge clk);
    chk(nvalid[0] == nv0, "R8", "no output from idle msg_valid", nvalid[0], nv0);
  endtask

  task automatic t_back_to_back();
    logic [3:0] ms [3] = '{4'b1101, 4'b0011, 4'b1110};
    int base = ndone[0];
    @(negedge clk);
    for (int j = 0; j < 3; j++) begin
      drive(1, 1, ms[j][3]);
      for (int i = 2; i >= 0; i--) begin @(negedge clk); drive(0, 1, ms[j][i]); end
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (a_done) break;
        drive(0, 0, 0);
      end
    end
    drive(0, 0, 0);
    repeat (3) @(negedge clk);
    for (int j = 0; j < 3; j++)
      for (int u = 0; u < 2; u++) begin
        chk(hist[u][(base + j) % 64] == ref_cw(ms[j], u), "R9", "chained codeword",
            hist[u][(base + j) % 64], ref_cw(ms[j], u));
        if (j > 0)
          chk(gap_h[u][(base + j) % 64] == 1, "R9", "first bit right after done",
              gap_h[u][(base + j) % 64], 1);
      end
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_all_messages();
    t_gaps();
    t_busy_start();
    t_ignore();
    t_idle_quiet();
    t_back_to_back();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule